// File: doc/BRIEF.md
# Power-State Request Handshake Register Block

This block carries power-state change requests from a PCI host to a local processor and returns the processor's answer. On the host side it watches writes to the power-management control/status register. A PowerState write records which device state was asked for in a sticky request flag and withdraws the "transition done" indication. The local processor reads the flags, carries out the transition, clears the flags by writing 1 to them, and then sets the done flag. The host sees these flags in a read-only view.

The local side can also request a wake-up. Writing the wake bit drives the active-low PME# pin while the host has wake enabled. Only the host can end the wake: it writes 1 to PME_Status or clears PME_En. A separate host-side software-reset strobe sets a reset-request flag. That flag drives the local interrupt directly until the processor acknowledges it.

The local register port is 32 bits wide with word offsets. Offset 0 is the power control register and offset 1 is the reset status register. Read data is registered and appears one cycle after the address.

Top module: `pm_handshake_regs`

## Requirements
- R1: While `rst` is high and in the cycle after it, all request flags, the done flag, the wake-pending state, PME_En and the reset request are 0, `pme_n` is 1 and `l_irq` is 0.
- R2: A host write with `h_be[0]` set loads PowerState from `h_wdata[1:0]` (00=D0, 01=D1, 10=D2, 11=D3). It sets the request flag at offset-0 bit 3 for D0, bit 2 for D1 and bit 0 for D3, and sets no flag for D2. A host write without `h_be[0]` changes neither the flags nor PowerState.
- R3: A local write to offset 0 clears each request flag whose data bit is 1 and leaves the flags with a 0 data bit unchanged. If the host sets the same flag in that cycle, the flag ends up set.
- R4: A local write to offset 0 loads the done flag (bit 31) from data bit 31. Any host PowerState write clears it, and this wins over a local write in the same cycle.
- R5: Local reads return the addressed register one cycle after `l_addr` is presented. At offset 0, bits 30, 29:4 and 1 read as 0. Offsets other than 0 and 1 read as 0.
- R6: A local write to offset 0 with bit 30 set makes a wake pending. From the next cycle, `pme_n` is the inverse of (pending AND PME_En), and `h_pmcs_rdata[15]` (PME_Status) reads as the pending state. A second wake write while a wake is pending changes nothing.
- R7: A host write with `h_be[1]` loads PME_En from `h_wdata[8]`. If `h_wdata[15]` is 1 in that write, it clears the pending wake, unless a local wake write arrives in the same cycle, in which case the wake stays pending.
- R8: `h_swrst_wr` sets the reset request. `l_irq` equals that request, and it reads as bit 0 at offset 1. A local write to offset 1 with bit 0 set clears it, unless `h_swrst_wr` arrives in the same cycle.
- R9: `h_pwr_view` always equals the offset-0 register contents: done flag, request flags and zero reserved bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe to the power-management control/status register |
| h_be | input | 2 | Host byte enables: byte 0 holds PowerState, byte 1 holds PME_En and PME_Status |
| h_wdata | input | 16 | Host write data (PowerState 1:0, PME_En 8, PME_Status 15) |
| h_swrst_wr | input | 1 | Host write strobe to the software-reset register |
| h_pmcs_rdata | output | 16 | Host view of the control/status register |
| h_pwr_view | output | 32 | Host read-only view of the local power control register |
| l_addr | input | 4 | Local word offset |
| l_wr | input | 1 | Local write strobe |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one cycle after the address |
| pme_n | output | 1 | Active-low power-management event output |
| l_irq | output | 1 | Local interrupt, level of the reset request |

## Verification
The hardest cases to reach are the same-cycle collisions between the two sides. These are a host PowerState write against a local clear-and-set-done write, a host PME_Status clear against a local wake write, and a software-reset strobe against its acknowledge. A random sequence would rarely line them up on one clock edge. Directed cycles therefore drive both ports in the same cycle for each collision. A long random phase follows, with dense host and local traffic, and a behavioural model checks every output on every cycle.

// File: rtl/pm_hs_pkg.sv
package pm_hs_pkg;
  localparam int LREG_W   = 32;
  localparam int LADDR_W  = 4;
  localparam int CFG_W    = 16;
  localparam int RDY_BIT  = 31;
  localparam int WAKE_BIT = 30;
  localparam int NREQ     = 3;
  localparam int PS_W     = 2;
  localparam int EN_BIT   = 8;
  localparam int STAT_BIT = 15;
  localparam int ACK_BIT  = 0;
  localparam logic [LADDR_W-1:0] OFF_PWR = 4'd0;
  localparam logic [LADDR_W-1:0] OFF_RST = 4'd1;

  typedef enum logic [PS_W-1:0] {PS_D0 = 2'b00, PS_D1 = 2'b01, PS_D2 = 2'b10, PS_D3 = 2'b11} pstate_e;

  // request flag index -> (state it tracks, bit position in the register)
  function automatic pstate_e req_state(input int idx);
    case (idx)
      0:       return PS_D0;
      1:       return PS_D1;
      default: return PS_D3;
    endcase
  endfunction

  function automatic int req_bit(input int idx);
    case (idx)
      0:       return 3;
      1:       return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pm_req_flags.sv
module pm_req_flags
  import pm_hs_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ps_wr,
  input  pstate_e      ps_val,
  input  logic         loc_wr,
  input  logic [N-1:0] loc_clr,
  input  logic         loc_rdy,
  output logic [N-1:0] req,
  output logic         ready
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic set_i;
    assign set_i = ps_wr && (ps_val == req_state(i));
    always_ff @(posedge clk) begin
      if (rst)                       req[i] <= 1'b0;
      else if (set_i)                req[i] <= 1'b1;
      else if (loc_wr && loc_clr[i]) req[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ready <= 1'b0;
    else if (ps_wr)  ready <= 1'b0;
    else if (loc_wr) ready <= loc_rdy;
  end
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl (
  input  logic clk,
  input  logic rst,
  input  logic loc_wake,
  input  logic h_cfg_we,
  input  logic h_en_val,
  input  logic h_stat_w1,
  output logic pend,
  output logic pme_en,
  output logic pme_n
);
  logic pend_nxt, en_nxt;

  always_comb begin
    pend_nxt = pend;
    if (loc_wake)                  pend_nxt = 1'b1;
    else if (h_cfg_we && h_stat_w1) pend_nxt = 1'b0;
    en_nxt = h_cfg_we ? h_en_val : pme_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      pme_en <= 1'b0;
      pme_n  <= 1'b1;
    end else begin
      pend   <= pend_nxt;
      pme_en <= en_nxt;
      pme_n  <= ~(pend_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/pm_swrst_ctl.sv
module pm_swrst_ctl (
  input  logic clk,
  input  logic rst,
  input  logic h_trig,
  input  logic loc_ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)          req <= 1'b0;
    else if (h_trig)  req <= 1'b1;
    else if (loc_ack) req <= 1'b0;
  end
endmodule

// File: rtl/pm_handshake_regs.sv
module pm_handshake_regs
  import pm_hs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               h_wr,
  input  logic [1:0]         h_be,
  input  logic [CFG_W-1:0]   h_wdata,
  input  logic               h_swrst_wr,
  output logic [CFG_W-1:0]   h_pmcs_rdata,
  output logic [LREG_W-1:0]  h_pwr_view,
  input  logic [LADDR_W-1:0] l_addr,
  input  logic               l_wr,
  input  logic [LREG_W-1:0]  l_wdata,
  output logic [LREG_W-1:0]  l_rdata,
  output logic               pme_n,
  output logic               l_irq
);
  logic              ps_wr, loc_pwr_wr, loc_rst_wr;
  logic [NREQ-1:0]   req, loc_clr;
  logic              ready, pend, pme_en, rst_req;
  pstate_e           pstate;
  logic [LREG_W-1:0] pwr_reg, rd_mux;

  assign ps_wr      = h_wr && h_be[0];
  assign loc_pwr_wr = l_wr && (l_addr == OFF_PWR);
  assign loc_rst_wr = l_wr && (l_addr == OFF_RST);

  for (genvar i = 0; i < NREQ; i++) begin : g_clr
    assign loc_clr[i] = l_wdata[req_bit(i)];
  end

  always_ff @(posedge clk) begin
    if (rst)        pstate <= PS_D0;
    else if (ps_wr) pstate <= pstate_e'(h_wdata[PS_W-1:0]);
  end

  pm_req_flags #(.N(NREQ)) u_flags (
    .clk(clk), .rst(rst), .ps_wr(ps_wr), .ps_val(pstate_e'(h_wdata[PS_W-1:0])),
    .loc_wr(loc_pwr_wr), .loc_clr(loc_clr), .loc_rdy(l_wdata[RDY_BIT]),
    .req(req), .ready(ready)
  );

  pm_wake_ctl u_wake (
    .clk(clk), .rst(rst), .loc_wake(loc_pwr_wr && l_wdata[WAKE_BIT]),
    .h_cfg_we(h_wr && h_be[1]), .h_en_val(h_wdata[EN_BIT]), .h_stat_w1(h_wdata[STAT_BIT]),
    .pend(pend), .pme_en(pme_en), .pme_n(pme_n)
  );

  pm_swrst_ctl u_swrst (
    .clk(clk), .rst(rst), .h_trig(h_swrst_wr),
    .loc_ack(loc_rst_wr && l_wdata[ACK_BIT]), .req(rst_req)
  );

  always_comb begin
    pwr_reg          = '0;
    pwr_reg[RDY_BIT] = ready;
    for (int i = 0; i < NREQ; i++) pwr_reg[req_bit(i)] = req[i];
  end

  always_comb begin
    rd_mux = '0;
    if (l_addr == OFF_PWR)      rd_mux = pwr_reg;
    else if (l_addr == OFF_RST) rd_mux[ACK_BIT] = rst_req;
  end

  always_ff @(posedge clk) begin
    if (rst) l_rdata <= '0;
    else     l_rdata <= rd_mux;
  end

  always_comb begin
    h_pmcs_rdata           = '0;
    h_pmcs_rdata[PS_W-1:0] = pstate;
    h_pmcs_rdata[EN_BIT]   = pme_en;
    h_pmcs_rdata[STAT_BIT] = pend;
  end

  assign h_pwr_view = pwr_reg;
  assign l_irq      = rst_req;
endmodule

// File: rtl/pm_hs_checker.sv
module pm_hs_checker
  import pm_hs_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               h_wr,
  input logic [1:0]         h_be,
  input logic [CFG_W-1:0]   h_wdata,
  input logic               h_swrst_wr,
  input logic [CFG_W-1:0]   h_pmcs_rdata,
  input logic [LREG_W-1:0]  h_pwr_view,
  input logic [LADDR_W-1:0] l_addr,
  input logic               l_wr,
  input logic               pme_n,
  input logic               l_irq
);
  assert_reset_R1: assert property (@(posedge clk) $past(rst) |-> (pme_n && !l_irq && h_pwr_view == '0));

  assert_d3_set_R2: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_be[0] && h_wdata[1:0] == 2'b11) |=> h_pwr_view[0]);

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_be[0]) |=> !h_pwr_view[RDY_BIT]);

  assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    (h_pwr_view[30:4] == '0) && !h_pwr_view[1]);

  assert_pme_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!pme_n && !(h_wr && h_be[1])) |=> !pme_n);

  assert_pme_status_R6: assert property (@(posedge clk) disable iff (rst)
    !pme_n |-> h_pmcs_rdata[STAT_BIT]);

  assert_swrst_irq_R8: assert property (@(posedge clk) disable iff (rst)
    h_swrst_wr |=> l_irq);

  assert_irq_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!h_swrst_wr && !(l_wr && l_addr == OFF_RST)) |=> $stable(l_irq));
endmodule

bind pm_handshake_regs pm_hs_checker u_chk (
  .clk(clk), .rst(rst), .h_wr(h_wr), .h_be(h_be), .h_wdata(h_wdata),
  .h_swrst_wr(h_swrst_wr), .h_pmcs_rdata(h_pmcs_rdata), .h_pwr_view(h_pwr_view),
  .l_addr(l_addr), .l_wr(l_wr), .pme_n(pme_n), .l_irq(l_irq)
);

// File: tb/pm_handshake_regs_tb.sv
module pm_handshake_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        h_wr = 0, h_swrst_wr = 0, l_wr = 0;
  logic [1:0]  h_be = 0;
  logic [15:0] h_wdata = 0;
  logic [3:0]  l_addr = 0;
  logic [31:0] l_wdata = 0;
  logic [15:0] h_pmcs_rdata;
  logic [31:0] h_pwr_view, l_rdata;
  logic        pme_n, l_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_handshake_regs u_dut (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_be(h_be), .h_wdata(h_wdata),
    .h_swrst_wr(h_swrst_wr), .h_pmcs_rdata(h_pmcs_rdata), .h_pwr_view(h_pwr_view),
    .l_addr(l_addr), .l_wr(l_wr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .pme_n(pme_n), .l_irq(l_irq)
  );

  // behavioural reference model
  bit m_d0, m_d1, m_d3, m_rdy, m_pend, m_en, m_rq;
  int m_ps;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_pwr();
    logic [31:0] v = 0;
    v[31] = m_rdy; v[3] = m_d0; v[2] = m_d1; v[0] = m_d3;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_d0, m_d1, m_d3, m_rdy, m_pend, m_en, m_rq} = 0; m_ps = 0; m_rdata = 0;
    end else begin
      bit lw0, lw1, psw, hb1;
      m_rdata = (l_addr == 0) ? m_pwr() : (l_addr == 1) ? {31'b0, m_rq} : 32'b0;
      lw0 = l_wr && l_addr == 0; lw1 = l_wr && l_addr == 1;
      psw = h_wr && h_be[0]; hb1 = h_wr && h_be[1];
      if (lw0 && l_wdata[3]) m_d0 = 0;
      if (lw0 && l_wdata[2]) m_d1 = 0;
      if (lw0 && l_wdata[0]) m_d3 = 0;
      if (lw0) m_rdy = l_wdata[31];
      if (psw) begin
        m_ps = h_wdata[1:0]; m_rdy = 0;
        if (m_ps == 0) m_d0 = 1;
        if (m_ps == 1) m_d1 = 1;
        if (m_ps == 3) m_d3 = 1;
      end
      if (hb1 && h_wdata[15]) m_pend = 0;
      if (hb1) m_en = h_wdata[8];
      if (lw0 && l_wdata[30]) m_pend = 1;
      if (lw1 && l_wdata[0]) m_rq = 0;
      if (h_swrst_wr) m_rq = 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check("R9 view", h_pwr_view, m_pwr());
    check("R5 rdata", l_rdata, m_rdata);
    check("R6 pme_n", {31'b0, pme_n}, {31'b0, ~(m_pend & m_en)});
    check("R8 irq", {31'b0, l_irq}, {31'b0, m_rq});
    check("R7 pmcs", {16'b0, h_pmcs_rdata}, {16'b0, m_pend, 6'b0, m_en, 6'b0, m_ps[1:0]});
  end

  task automatic cyc(bit hw, logic [1:0] be, logic [15:0] hd, bit sw,
                     bit lw, logic [3:0] la, logic [31:0] ld);
    h_wr = hw; h_be = be; h_wdata = hd; h_swrst_wr = sw;
    l_wr = lw; l_addr = la; l_wdata = ld;
    @(negedge clk);
    h_wr = 0; h_swrst_wr = 0; l_wr = 0;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pme_n", {31'b0, pme_n}, 32'd1);
    check("R1 reset irq", {31'b0, l_irq}, 32'd0);
    rst = 0;
    idle();
    check("R1 after reset view", h_pwr_view, 32'h0);
    // R2 request flags
    cyc(1, 2'b01, 16'h0003, 0, 0, 0, 0);
    check("R2 D3 flag", h_pwr_view, 32'h0000_0001);
    cyc(1, 2'b01, 16'h0001, 0, 0, 0, 0);
    check("R2 D1 flag", h_pwr_view, 32'h0000_0005);
    cyc(0, 0, 0, 0, 1, 0, 32'h8000_0000);
    check("R4 ready set", h_pwr_view, 32'h8000_0005);
    cyc(1, 2'b01, 16'h0002, 0, 0, 0, 0);
    check("R2 D2 no flag, R4 ready drop", h_pwr_view, 32'h0000_0005);
    cyc(1, 2'b10, 16'h0000, 0, 0, 0, 0);
    check("R2 no be0 pstate kept", {30'b0, h_pmcs_rdata[1:0]}, 32'd2);
    // R3 clear and collision
    cyc(0, 0, 0, 0, 1, 0, 32'h8000_0001);
    check("R3 clear D3", h_pwr_view, 32'h8000_0004);
    cyc(1, 2'b01, 16'h0001, 0, 1, 0, 32'h8000_0004);
    check("R3 set wins, R4 host wins", h_pwr_view, 32'h0000_0004);
    cyc(1, 2'b01, 16'h0000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check("R5 read off0", l_rdata, 32'h0000_000C);
    cyc(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    check("R3 clear all, R5 reserved", l_rdata, 32'h0000_000C);
    idle();
    check("R5 rsvd zero", l_rdata, 32'h8000_0000);
    // R6/R7 wake
    cyc(1, 2'b10, 16'h0100, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 32'h4000_0000);
    check("R6 pme asserted", {31'b0, pme_n}, 32'd0);
    check("R6 status", {31'b0, h_pmcs_rdata[15]}, 32'd1);
    check("R6 wake reads 0", h_pwr_view, 32'h0000_0000);
    cyc(0, 0, 0, 0, 1, 0, 32'h4000_0000);
    check("R6 repeat", {31'b0, pme_n}, 32'd0);
    cyc(1, 2'b10, 16'h8100, 0, 1, 0, 32'h4000_0000);
    check("R7 wake beats clear", {31'b0, pme_n}, 32'd0);
    cyc(1, 2'b10, 16'h8100, 0, 0, 0, 0);
    check("R7 status clear", {31'b0, pme_n}, 32'd1);
    cyc(0, 0, 0, 0, 1, 0, 32'h4000_0000);
    cyc(1, 2'b10, 16'h0000, 0, 0, 0, 0);
    check("R7 en clear", {31'b0, pme_n}, 32'd1);
    check("R7 status kept", {31'b0, h_pmcs_rdata[15]}, 32'd1);
    // R8 soft reset
    cyc(0, 0, 0, 1, 0, 0, 0);
    check("R8 irq set", {31'b0, l_irq}, 32'd1);
    cyc(0, 0, 0, 1, 1, 1, 32'h1);
    check("R8 set wins", {31'b0, l_irq}, 32'd1);
    cyc(0, 0, 0, 0, 1, 1, 32'h1);
    check("R8 read off1", l_rdata, 32'd1);
    check("R8 ack clear", {31'b0, l_irq}, 32'd0);
    cyc(0, 0, 0, 0, 0, 4'd5, 0);
    idle();
    check("R5 unmapped", l_rdata, 32'd0);
    // random phase, model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] hd = $urandom;
      logic [31:0] ld = $urandom;
      cyc($urandom_range(0, 2) == 0, 2'($urandom), hd, $urandom_range(0, 9) == 0,
          $urandom_range(0, 2) == 0, 4'($urandom_range(0, 2)), ld);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule